// File: doc/BRIEF.md
# Carry-Select Adder with Accumulator

This block adds two 10-bit operands and a carry-in. The adder is split into two 5-bit sections. Each section runs two ripple chains side by side: one chain assumes an incoming carry of 0 and the other assumes 1. Both chains finish before the real carry is known. The real carry then picks one result for each section. The carry chosen for the low section becomes the select input of the high section. Only these section-boundary selections lie on the long timing path. The carry from the top section is brought out so that a further adder stage can be chained after this one.

A 2-bit mode input decides what the outputs show. In the two pass-through codes, the adder result goes straight to the pins. In load mode, an output register captures the adder result. In accumulate mode, the register feeds back in place of operand A, so each enabled edge adds B and the carry-in to the running total. Reset is synchronous and active low. A low enable freezes the register.

Top module: `csel_accum`

## Requirements
- R1: When mode_i is 2'b00 or 2'b11 (pass-through), {cout_o, sum_o} equals a_i + b_i + cin_i in the same cycle, with no clock edge needed, for every operand pair.
- R2: The all-ones case in pass-through mode, 10'h3FF + 10'h3FF + 1, gives sum_o = 10'h3FF and cout_o = 1.
- R3: A carry that crosses the boundary between bit 4 and bit 5 is handled correctly. In pass-through, 10'h01F + 10'h000 + 1 gives sum_o = 10'h020 and cout_o = 0. Likewise 10'h3FF + 0 + 1 gives sum_o = 0 and cout_o = 1.
- R4: With mode_i = 2'b01 (load) and en_i high, a rising edge stores a_i + b_i + cin_i into the sum register and its carry into the carry register. Both outputs then show the stored values.
- R5: With mode_i = 2'b10 (accumulate) and en_i high, a rising edge stores register + b_i + cin_i (modulo 2^10) and the carry of that addition. a_i is ignored in this mode.
- R6: With en_i low, a rising edge leaves the sum register and the carry register unchanged.
- R7: With rst_n low, a rising edge clears both registers to zero. This holds whatever en_i and mode_i are.
- R8: In pass-through mode the registers are never written, even with en_i high. The stored value is still there when a registered mode is selected again.
- R9: In load and accumulate modes, sum_o and cout_o show the registers. Changing a_i, b_i or cin_i between edges does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Register update enable |
| mode_i | input | 2 | 00/11 pass-through, 01 load, 10 accumulate |
| a_i | input | 10 | Operand A (not used in accumulate mode) |
| b_i | input | 10 | Operand B |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 10 | Sum, either combinational or registered, depending on mode |
| cout_o | output | 1 | Carry out of the top section, for chaining |

## Verification
Two of the block's functions can fall in the same cycle: the synchronous clear and an enabled accumulate step. In that case the clear must win.

The bench provokes this by holding rst_n low while en_i is high, mode_i is accumulate, and all-ones operands would produce a carry. It then checks that both outputs read zero after the edge. The bench also sets en_i high during the whole pass-through sweep. It then confirms that the stored total survived untouched, so pass-through use and register holding are judged together.

// File: rtl/csel_pkg.sv
// Package: shared mode encoding for the carry-select adder/accumulator.
// Assumes: a 2-bit mode field; the spare code behaves as pass-through.
package csel_pkg;

    typedef enum logic [1:0] {
        MODE_PASS     = 2'b00,
        MODE_LOAD     = 2'b01,
        MODE_ACCUM    = 2'b10,
        MODE_PASS_ALT = 2'b11
    } csel_mode_e;

endpackage

// File: rtl/csel_chain.sv
// Module: csel_chain
// A ripple chain of W bit-cells with a fixed carry-in value.
// Each cell passes its carry up to the next-higher cell.
// Assumes: CARRY_SEED is known at build time (the chain is precomputed).
module csel_chain #(
    parameter int W          = 5,
    parameter bit CARRY_SEED = 1'b0
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         carry_out
);

    logic [W:0] c;

    // Seed the chain with its assumed carry.
    assign c[0] = CARRY_SEED;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_cell
            logic prop;
            // One bit-cell: propagate, sum, and carry to the next bit.
            assign prop     = op_a[i] ^ op_b[i];
            assign sum[i]   = prop ^ c[i];
            assign c[i+1]   = (op_a[i] & op_b[i]) | (prop & c[i]);
        end
    endgenerate

    assign carry_out = c[W];

endmodule

// File: rtl/csel_section.sv
// Module: csel_section
// One carry-select section. It builds two chains, seeded with 0 and 1,
// and uses the section carry-in to pick one sum/carry pair.
// Assumes: sel_cin settles later than the operands (it is the critical input).
module csel_section #(
    parameter int W = 5
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sel_cin,
    output logic [W-1:0] sum,
    output logic         carry_out
);

    logic [W-1:0] pre_sum [2];
    logic         pre_cy  [2];

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_chain
            csel_chain #(
                .W          (W),
                .CARRY_SEED (k == 1)
            ) u_chain (
                .op_a      (op_a),
                .op_b      (op_b),
                .sum       (pre_sum[k]),
                .carry_out (pre_cy[k])
            );
        end
    endgenerate

    // Pick the precomputed result that matches the real carry-in.
    always_comb begin
        if (sel_cin) begin
            sum       = pre_sum[1];
            carry_out = pre_cy[1];
        end else begin
            sum       = pre_sum[0];
            carry_out = pre_cy[0];
        end
    end

endmodule

// File: rtl/csel_adder.sv
// Module: csel_adder
// NUM_SECT carry-select sections of SECT_W bits each. The carry chosen in
// each section drives the select input of the next section up.
// Assumes: purely combinational; no registers inside.
module csel_adder #(
    parameter int SECT_W   = 5,
    parameter int NUM_SECT = 2,
    localparam int W       = SECT_W * NUM_SECT
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [NUM_SECT:0] sect_cy;

    // The block carry-in selects inside the lowest section.
    assign sect_cy[0] = cin;

    genvar s;
    generate
        for (s = 0; s < NUM_SECT; s++) begin : g_sect
            csel_section #(
                .W (SECT_W)
            ) u_sect (
                .op_a      (op_a[s*SECT_W +: SECT_W]),
                .op_b      (op_b[s*SECT_W +: SECT_W]),
                .sel_cin   (sect_cy[s]),
                .sum       (sum[s*SECT_W +: SECT_W]),
                .carry_out (sect_cy[s+1])
            );
        end
    endgenerate

    assign cout = sect_cy[NUM_SECT];

endmodule

// File: rtl/csel_accum.sv
// Module: csel_accum (top)
// Carry-select adder with an output register that can be bypassed,
// loaded, or fed back to act as an accumulator.
// Assumes: single clock; synchronous active-low reset; inputs change away
// from the rising edge.
module csel_accum
    import csel_pkg::*;
#(
    parameter int SECT_W   = 5,
    parameter int NUM_SECT = 2,
    localparam int W       = SECT_W * NUM_SECT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    csel_mode_e   mode;
    logic         is_accum;
    logic         is_load;
    logic         use_reg;
    logic [W-1:0] opnd_a;
    logic [W-1:0] add_sum;
    logic         add_cy;
    logic [W-1:0] acc_q;
    logic         cy_q;

    // Decode the mode field.
    always_comb begin
        mode     = csel_mode_e'(mode_i);
        is_accum = (mode == MODE_ACCUM);
        is_load  = (mode == MODE_LOAD);
        use_reg  = is_accum | is_load;
    end

    // In accumulate mode the stored total takes the place of operand A.
    assign opnd_a = is_accum ? acc_q : a_i;

    csel_adder #(
        .SECT_W   (SECT_W),
        .NUM_SECT (NUM_SECT)
    ) u_adder (
        .op_a (opnd_a),
        .op_b (b_i),
        .cin  (cin_i),
        .sum  (add_sum),
        .cout (add_cy)
    );

    // Result register: clear on reset; write only when enabled in a registered mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cy_q  <= 1'b0;
        end else if (en_i && use_reg) begin
            acc_q <= add_sum;
            cy_q  <= add_cy;
        end
    end

    // Output select: register in registered modes, adder directly otherwise.
    assign sum_o  = use_reg ? acc_q : add_sum;
    assign cout_o = use_reg ? cy_q  : add_cy;

endmodule

// File: rtl/csel_accum_chk.sv
// Module: csel_accum_chk
// Checker for csel_accum, attached with bind. It compares the adder against
// plain arithmetic and checks the register update rules.
module csel_accum_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_i,
    input logic [1:0]   mode_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         cin_i,
    input logic [W-1:0] sum_o,
    input logic         cout_o,
    input logic [W-1:0] acc_q,
    input logic         cy_q
);

    // R1: pass-through result matches arithmetic.
    p_pass_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 || mode_i == 2'b11) |->
        ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i))));

    // R4: load stores a + b + cin.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && mode_i == 2'b01) |=>
        ({cy_q, acc_q} == $past({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i))));

    // R5: accumulate adds b + cin to the stored total.
    p_accum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && mode_i == 2'b10) |=>
        ({cy_q, acc_q} == $past({1'b0, acc_q} + {1'b0, b_i} + (W+1)'(cin_i))));

    // R6: a low enable holds the register.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(acc_q) && $stable(cy_q)));

    // R8: pass-through mode never writes the register.
    p_pass_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 || mode_i == 2'b11) |=> ($stable(acc_q) && $stable(cy_q)));

    // R7: a sampled low reset leaves the register cleared.
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && cy_q == 1'b0));

    // R9: registered modes show the register at the pins.
    p_reg_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 || mode_i == 2'b10) |-> (sum_o == acc_q && cout_o == cy_q));

endmodule

bind csel_accum csel_accum_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .mode_i (mode_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .acc_q  (acc_q),
    .cy_q   (cy_q)
);

// File: tb/csel_accum_tb.sv
module csel_accum_tb;

    localparam int W = 10;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         cin_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         cout_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    csel_accum u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .mode_i (mode_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .sum_o  (sum_o),
        .cout_o (cout_o)
    );

    task automatic check(input string tag, input logic [W:0] exp);
        checks++;
        if ({cout_o, sum_o} !== exp) begin
            errors++;
            $display("FAIL %s: got cout=%0b sum=%03h, expected cout=%0b sum=%03h",
                     tag, cout_o, sum_o, exp[W], exp[W-1:0]);
        end
    endtask

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] acc;
        logic         acy;
        logic [W:0]   r;

        // R7: reset wins over an enabled accumulate step with all-ones inputs.
        rst_n = 0; en_i = 1; mode_i = 2'b10; a_i = MASK; b_i = MASK; cin_i = 1;
        @(negedge clk); @(negedge clk);
        check("R7 reset clears", '0);

        // Set up a known stored value (R4) before the pass-through sweep.
        rst_n = 1; mode_i = 2'b01; a_i = 10'h155; b_i = 10'h0AA; cin_i = 1;
        @(negedge clk);
        check("R4 load", ref_add(10'h155, 10'h0AA, 1'b1));

        // R1 sweep with enable high, alternating the two pass-through codes.
        en_i = 1;
        for (int a = 0; a < 1024; a++) begin
            for (int j = 0; j < 6; j++) begin
                logic [W-1:0] bv;
                case (j)
                    0: bv = '0;
                    1: bv = 10'h001;
                    2: bv = 10'h01F;
                    3: bv = MASK;
                    4: bv = ~a[W-1:0];
                    default: bv = W'((a * 37 + 11) & 1023);
                endcase
                for (int c = 0; c < 2; c++) begin
                    mode_i = a[0] ? 2'b11 : 2'b00;
                    a_i = a[W-1:0]; b_i = bv; cin_i = c[0];
                    #2;
                    check("R1 pass-through", ref_add(a[W-1:0], bv, c[0]));
                end
            end
            @(negedge clk);
        end

        // R2 all ones.
        mode_i = 2'b00; a_i = MASK; b_i = MASK; cin_i = 1; #2;
        check("R2 all ones", {1'b1, MASK});
        // R3 section boundary ripple.
        a_i = 10'h01F; b_i = 10'h000; cin_i = 1; #2;
        check("R3 boundary ripple", {1'b0, 10'h020});
        a_i = MASK; b_i = 10'h000; cin_i = 1; #2;
        check("R3 full ripple", {1'b1, 10'h000});
        a_i = 10'h010; b_i = 10'h00F; cin_i = 1; #2;
        check("R3 boundary carry", {1'b0, 10'h020});

        // R8: the register survived pass-through use with en high.
        @(negedge clk);
        en_i = 0; mode_i = 2'b10; #2;
        check("R8 register kept", ref_add(10'h155, 10'h0AA, 1'b1));

        // R4 several loads, each followed by an R9 input-change check.
        en_i = 1; mode_i = 2'b01;
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] av, bv;
            logic cv;
            av = W'((k * 97 + 3) & 1023); bv = W'((k * 211 + 500) & 1023); cv = k[1];
            if (k == 0) begin av = MASK; bv = MASK; cv = 1; end
            a_i = av; b_i = bv; cin_i = cv;
            @(negedge clk);
            check("R4 load", ref_add(av, bv, cv));
            a_i = ~av; b_i = ~bv; cin_i = ~cv; #2;
            check("R9 outputs held between edges", ref_add(av, bv, cv));
        end

        // R5 accumulate from a loaded start; a_i is garbage.
        a_i = 10'h3F0; b_i = 10'h00F; cin_i = 0;
        @(negedge clk);
        acc = 10'h3FF; acy = 0;
        mode_i = 2'b10;
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] bv;
            logic cv;
            bv = W'((k * 53 + 7) & 1023); cv = k[0];
            a_i = W'((k * 71) & 1023); b_i = bv; cin_i = cv;
            @(negedge clk);
            r = ref_add(acc, bv, cv);
            acc = r[W-1:0]; acy = r[W];
            check("R5 accumulate", {acy, acc});
        end

        // R6 hold with enable low in accumulate and load modes.
        en_i = 0;
        for (int k = 0; k < 6; k++) begin
            mode_i = k[0] ? 2'b01 : 2'b10; a_i = W'(k * 100); b_i = MASK; cin_i = 1;
            @(negedge clk);
            check("R6 hold", {acy, acc});
        end

        // R7 reset during an accumulate run.
        en_i = 1; mode_i = 2'b10; rst_n = 0; b_i = 10'h200; cin_i = 1;
        @(negedge clk);
        check("R7 reset mid-run", '0);
        rst_n = 1; b_i = 10'h005; cin_i = 1;
        @(negedge clk);
        check("R5 accumulate after reset", {1'b0, 10'h006});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule